// File: doc/BRIEF.md
# Peripheral Interrupt and Soft-Reset Unit

This block sits beside a serial-peripheral core and gathers that core's six event pulses into sticky status bits. Each status bit is masked by its own enable bit, and one master enable gates the combined result. Together they drive a single level-sensitive interrupt line toward the processor. A handler reads the status word, writes the same value back to acknowledge exactly the events it saw, and can mask or unmask sources at any time.

The same register port also carries a soft-reset register. Only one key value starts a reset. That write launches a fixed-length reset pulse toward the attached core. While the pulse is active, the unit holds its own status, enable and master-enable registers at zero.

The register port is a plain 32-bit interface: one write strobe, one byte address, write data, and read data that follows the address combinationally. Register offsets, the reset key, the pulse length and the number of sources are parameters.

Top module: `pirq_unit`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `core_rst_o` is low.
- R2: A pulse on `evt_i[i]` sets status bit i on the next clock edge, whatever the enable bits hold. Bit i stays set until it is cleared. The source order is: bit 0 mode fault, bit 1 slave-select fault, bit 2 transmit FIFO empty, bit 3 transmit underrun, bit 4 receive FIFO full, bit 5 receive overrun. The status register sits at offset 0x20 and reads back in bits [5:0].
- R3: A write to offset 0x20 clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R4: When an event pulse and a clear of the same bit fall in the same cycle, that bit stays set.
- R5: The enable register at offset 0x28 holds bits [5:0] and reads them back. Writing 0 masks every source, while events still set status bits.
- R6: The master enable is bit 31 of offset 0x1C. The other bits of that register read 0.
- R7: `irq_o` is high exactly when the master enable is 1 and some status bit and its enable bit are both 1. It follows the register state in the same cycle.
- R8: Writing exactly 0x0000000A to offset 0x40 while no reset pulse is running drives `core_rst_o` high from the next cycle for 16 cycles.
- R9: Writing any other value to offset 0x40 changes nothing. That offset always reads 0.
- R10: While `core_rst_o` is high, status, enable and master enable are held at 0. Events and register writes are ignored, and that includes a further key write.
- R11: A read of any offset other than the four registers returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 6 | Event pulses from the serial core |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | Reset pulse toward the serial core |

## Verification
The assertions check the following on every cycle:
- An event always sets its bit.
- A status bit never drops without a clear or a reset pulse.
- The hold during a pulse empties all three registers.
- A key write starts the pulse.
- A non-key write never starts it.
- The interrupt stays low while the master enable is 0.

Some behaviour only the bench scenarios can show:
- The exact 16-cycle pulse length.
- That a key write during a pulse is ignored.
- That set wins over clear in the same cycle.
- Readback of each offset against a model.

The bench exercises these under directed corner cases and a long seeded random mix.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   // Register selected by the current bus address.
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GIE,
      SEL_STAT,
      SEL_ENA,
      SEL_RST
   } pirq_sel_e;

endpackage

// File: rtl/pirq_status_bank.sv
module pirq_status_bank #(
   parameter int unsigned N_SRC = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             wr_stat,
   input  logic             wr_ena,
   input  logic             wr_gie,
   input  logic [N_SRC-1:0] wbits,
   input  logic             wtop,
   input  logic [N_SRC-1:0] evt,
   output logic [N_SRC-1:0] stat,
   output logic [N_SRC-1:0] ena,
   output logic             gie
);

   if (N_SRC < 1) begin : g_chk_nsrc
      $error("pirq_status_bank: N_SRC must be at least 1");
   end

   // One sticky flop per source; a new event has priority over a clear.
   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stat[i] <= 1'b0;
         else if (hold)   stat[i] <= 1'b0;
         else             stat[i] <= evt[i] | (stat[i] & ~(wr_stat & wbits[i]));
      end

      // R2: an event outside a reset pulse always lands
      a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (!hold && evt[i]) |=> stat[i]);

      // R3: a set bit survives unless cleared or held
      a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (stat[i] && !hold && !(wr_stat && wbits[i])) |=> stat[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ena <= '0;
      else if (hold)   ena <= '0;
      else if (wr_ena) ena <= wbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gie <= 1'b0;
      else if (hold)   gie <= 1'b0;
      else if (wr_gie) gie <= wtop;
   end

   // R10: a held cycle leaves all three registers empty
   a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (stat == '0 && ena == '0 && !gie));

endmodule

// File: rtl/pirq_reset_gen.sv
module pirq_reset_gen #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned RST_KEY   = 32'h0000_000A,
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_rst,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy
);

   localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_chk_len
      $error("pirq_reset_gen: PULSE_LEN must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             key_hit;

   assign key_hit = wr_rst && (wdata == DATA_W'(RST_KEY));
   assign busy    = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (busy)    cnt <= cnt - CNT_W'(1);
      else if (key_hit) cnt <= CNT_W'(PULSE_LEN);
   end

   // R8: key write while idle starts the pulse
   a_r8_key_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (key_hit && !busy) |=> busy);

   // R9: no pulse starts without the key
   a_r9_no_false_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !key_hit) |=> !busy);

endmodule

// File: rtl/pirq_unit.sv
module pirq_unit
   import pirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned N_SRC     = 6,
   parameter int unsigned OFS_GIE   = 'h1C,
   parameter int unsigned OFS_STAT  = 'h20,
   parameter int unsigned OFS_ENA   = 'h28,
   parameter int unsigned OFS_RST   = 'h40,
   parameter int unsigned RST_KEY   = 'h0A,
   parameter int unsigned PULSE_LEN = 16,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]  evt_i,
   output logic              irq_o,
   output logic              core_rst_o
);

   if (N_SRC >= DATA_W) begin : g_chk_width
      $error("pirq_unit: N_SRC must leave the top data bit free");
   end
   if (OFS_GIE == OFS_STAT || OFS_GIE == OFS_ENA || OFS_GIE == OFS_RST ||
       OFS_STAT == OFS_ENA || OFS_STAT == OFS_RST || OFS_ENA == OFS_RST) begin : g_chk_ofs
      $error("pirq_unit: register offsets must be distinct");
   end

   pirq_sel_e        sel;
   logic [N_SRC-1:0] stat, ena;
   logic             gie, irq_raw;

   always_comb begin
      sel = SEL_NONE;
      if      (bus_addr == ADDR_W'(OFS_GIE))  sel = SEL_GIE;
      else if (bus_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(OFS_ENA))  sel = SEL_ENA;
      else if (bus_addr == ADDR_W'(OFS_RST))  sel = SEL_RST;
   end

   pirq_status_bank #(.N_SRC(N_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (core_rst_o),
      .wr_stat (bus_wr && sel == SEL_STAT),
      .wr_ena  (bus_wr && sel == SEL_ENA),
      .wr_gie  (bus_wr && sel == SEL_GIE),
      .wbits   (bus_wdata[N_SRC-1:0]),
      .wtop    (bus_wdata[DATA_W-1]),
      .evt     (evt_i),
      .stat    (stat),
      .ena     (ena),
      .gie     (gie)
   );

   pirq_reset_gen #(
      .DATA_W    (DATA_W),
      .RST_KEY   (RST_KEY),
      .PULSE_LEN (PULSE_LEN)
   ) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_rst (bus_wr && sel == SEL_RST),
      .wdata  (bus_wdata),
      .busy   (core_rst_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_GIE:  bus_rdata[DATA_W-1]  = gie;
         SEL_STAT: bus_rdata[N_SRC-1:0] = stat;
         SEL_ENA:  bus_rdata[N_SRC-1:0] = ena;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_raw = gie & |(stat & ena);

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_raw;

      // R7: no request while the master enable is off
      a_r7_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
         !gie |-> !irq_o);
   end

endmodule

// File: tb/sim_pirq_unit.sv
module sim_pirq_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_GIE = 8'h1C, A_ST = 8'h20, A_EN = 8'h28, A_RST = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  evt_i = '0;
   logic        irq_o, core_rst_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference model state
   logic [5:0] m_st = '0, m_en = '0;
   logic       m_gie = 1'b0;
   int         m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pirq_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
      .irq_o(irq_o), .core_rst_o(core_rst_o)
   );

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         A_GIE:   return {m_gie, 31'd0};
         A_ST:    return {26'd0, m_st};
         A_EN:    return {26'd0, m_en};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // apply one cycle of stimulus, advance the model, check all outputs
   task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [5:0] e, input string tag);
      bus_wr = w; bus_addr = a; bus_wdata = d; evt_i = e;
      @(posedge clk);
      if (m_cnt != 0) begin
         m_st = '0; m_en = '0; m_gie = 1'b0; m_cnt--;
      end else begin
         m_st = ((w && a == A_ST) ? (m_st & ~d[5:0]) : m_st) | e;
         if (w && a == A_EN)  m_en = d[5:0];
         if (w && a == A_GIE) m_gie = d[31];
         if (w && a == A_RST && d == 32'h0000_000A) m_cnt = 16;
      end
      #1;
      chk({tag, " rdata"}, bus_rdata, exp_rd(a));
      chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_gie & |(m_st & m_en)});
      chk({tag, " core_rst"}, {31'd0, core_rst_o}, {31'd0, m_cnt != 0});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int hi;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
      chk("R1 core_rst", {31'd0, core_rst_o}, 32'd0);
      cyc(0, A_GIE, 0, 0, "R1 gie");
      cyc(0, A_ST, 0, 0, "R1 stat");
      cyc(0, A_EN, 0, 0, "R1 ena");
      cyc(0, A_RST, 0, 0, "R1 rst");

      // R2 event latches with enables off
      cyc(0, A_ST, 0, 6'h08, "R2 set bit3");
      cyc(0, A_ST, 0, 0, "R2 sticky");
      chk("R2 bit3", bus_rdata, 32'h08);
      // R5 enables, R6 master enable, R7 irq
      cyc(1, A_EN, 32'hFFFF_FFFF, 0, "R5 enable all");
      chk("R5 ena reads", bus_rdata, 32'h3F);
      chk("R7 no gie", {31'd0, irq_o}, 32'd0);
      cyc(1, A_GIE, 32'hFFFF_FFFF, 0, "R6 gie on");
      chk("R6 only bit31", bus_rdata, 32'h8000_0000);
      chk("R7 irq up", {31'd0, irq_o}, 32'd1);
      // R3 write-1-to-clear
      cyc(1, A_ST, 32'h08, 0, "R3 clear bit3");
      chk("R7 irq down", {31'd0, irq_o}, 32'd0);
      cyc(0, A_ST, 0, 6'h15, "R2 set 0x15");
      cyc(1, A_ST, 32'h05, 0, "R3 partial clear");
      chk("R3 leaves bit4", bus_rdata, 32'h10);
      // R4 set wins over clear
      cyc(1, A_ST, 32'h10, 6'h10, "R4 set vs clear");
      chk("R4 bit4 kept", bus_rdata, 32'h10);
      // R5 mask all
      cyc(1, A_EN, 0, 6'h01, "R5 mask");
      chk("R5 irq masked", {31'd0, irq_o}, 32'd0);
      cyc(0, A_ST, 0, 0, "R5 status kept");
      chk("R5 status", bus_rdata, 32'h11);
      // R9 bad keys
      cyc(1, A_RST, 32'h0B, 0, "R9 key 0x0B");
      cyc(1, A_RST, 32'h0000_010A, 0, "R9 key 0x10A");
      cyc(1, A_RST, 32'hFFFF_FFFF, 0, "R9 key ones");
      chk("R9 no pulse", {31'd0, core_rst_o}, 32'd0);
      cyc(0, A_ST, 0, 0, "R9 status intact");
      // R11 unmapped
      cyc(0, 8'h24, 0, 0, "R11 0x24");
      cyc(0, 8'hFF, 0, 0, "R11 0xFF");

      // R8 pulse length
      cyc(1, A_EN, 32'h3F, 0, "R8 prep");
      cyc(1, A_RST, 32'h0A, 0, "R8 key");
      hi = core_rst_o ? 1 : 0;
      for (int k = 0; k < 20; k++) begin
         cyc(0, A_ST, 0, 0, "R8 pulse");
         if (core_rst_o) hi++;
      end
      chk("R8 pulse length", hi, 16);
      cyc(0, A_EN, 0, 0, "R10 ena cleared");
      chk("R10 ena zero", bus_rdata, 32'd0);

      // R10 writes, events and key ignored during pulse
      cyc(1, A_RST, 32'h0A, 0, "R10 key");
      hi = 1;
      for (int k = 0; k < 20; k++) begin
         if (k == 3)      cyc(1, A_RST, 32'h0A, 6'h3F, "R10 rekey");
         else if (k == 5) cyc(1, A_GIE, 32'h8000_0000, 6'h01, "R10 gie wr");
         else             cyc(1, A_EN, 32'h3F, 6'h2A, "R10 ena wr");
         if (core_rst_o) hi++;
      end
      chk("R10 no extension", hi, 16);

      // seeded random mix
      for (int k = 0; k < 4000; k++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int sel = $urandom_range(0, 5);
         a = (sel == 0) ? A_GIE : (sel == 1) ? A_ST : (sel == 2) ? A_EN :
             (sel == 3) ? A_RST : 8'($urandom);
         d = $urandom;
         if (a == A_RST && $urandom_range(0, 7) == 0) d = 32'h0A;
         cyc(1'($urandom_range(0, 1)), a, d, 6'($urandom & $urandom & $urandom),
             "random R2 R3 R4 R7 R8 R10");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule